// File: doc/BRIEF.md
# Multi-Phase DDR Oversampling Aligner

This block recovers one double-data-rate serial bit stream of 480 Mb/s without a dedicated clock manager for the link. Three clocks at 240 MHz, spaced 60 degrees apart, supply six sampling edges through their rising and falling edges: 0, 60, 120, 180, 240 and 300 degrees. The serial line is therefore sampled at 1.44 GS/s, which gives three samples per bit. Every sample passes through three register stages. These stages settle metastability and bring the sample into the 0-degree clock domain.

Two 2-bit selects choose the samples. One picks which of the 0/60/120 samples is the bit for the rising edge. The other picks which of the 180/240/300 samples is the bit for the falling edge. The rising-edge bit is registered on the rising edge of the 0-degree clock and the falling-edge bit on its falling edge, so the block yields two parallel bit streams.

An optional eye finder takes over both selects. It watches where transitions fall between neighbouring samples over a window of programmable length. It then moves to the sample furthest from the transitions it saw.

Top module: `ddr_phase_aligner`

## Requirements
- R1: While `rst_n` is low, `dout_pos` and `dout_neg` are 0.
- R2: With `auto_en` low and `sel_pos` = 0, 1 or 2, the value on `din` at the 0, 60 or 120 degree edge of the clock period that starts at rising edge n of `clk_p0` appears on `dout_pos` just after rising edge n+2.
- R3: With `auto_en` low and `sel_neg` = 0, 1 or 2, the value on `din` at the 180, 240 or 300 degree edge of period n appears on `dout_neg` just after the falling edge of `clk_p0` in period n+2.
- R4: A select value of 3 holds the output of that edge. The held value is the last bit produced before the hold took effect.
- R5: `sel_pos` is registered on the rising edge of `clk_p0` and `sel_neg` on its falling edge. Each output gives exactly one bit per clock period, and a change of select neither repeats nor skips a period.
- R6: With `auto_en` high, the external selects are ignored. Both edges use the finder's pick, which is 1 after reset. If transitions were seen only between samples 0 and 1 (or 180 and 240), the pick becomes 2. If they were seen only between samples 1 and 2 (or 240 and 300), it becomes 0. If they were seen only between 300 and the next 0, it becomes 1.
- R7: The finder's pick changes only at the end of a window of `win_len` periods (0 counts as 1). A window that saw transitions in no class, or in more than one class, keeps the previous pick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_p0 | input | 1 | 240 MHz clock, 0 degrees (falling edge gives 180) |
| clk_p60 | input | 1 | 240 MHz clock, 60 degrees (falling edge gives 240) |
| clk_p120 | input | 1 | 240 MHz clock, 120 degrees (falling edge gives 300) |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Serial DDR data |
| sel_pos | input | 2 | Rising-edge sample select, 3 = hold |
| sel_neg | input | 2 | Falling-edge sample select, 3 = hold |
| auto_en | input | 1 | Let the eye finder drive both selects |
| win_len | input | WIN_W | Eye-finder window length in periods |
| dout_pos | output | 1 | Rising-edge bit stream |
| dout_neg | output | 1 | Falling-edge bit stream |

## Verification
A pseudo-random stream is driven with its bit boundaries at three offsets from the 0-degree edge. Each offset places the transitions inside a different gap between neighbouring samples. Under each offset, every manual select value is tried on both edges. Because some choices return the bit before or after the centred one, a wrong phase, edge or latency shows as a mismatch against the stream model. The three offsets are repeated with the finder enabled and the external selects set to conflicting values, so each gap class must map to its own pick. A hold step confirms that the frozen value is the exact last bit taken with the earlier select.

// File: rtl/ddr_phase_aligner.sv
module ddr_phase_aligner #(
  parameter int WIN_W = 8
) (
  input  logic             clk_p0,
  input  logic             clk_p60,
  input  logic             clk_p120,
  input  logic             rst_n,
  input  logic             din,
  input  logic [1:0]       sel_pos,
  input  logic [1:0]       sel_neg,
  input  logic             auto_en,
  input  logic [WIN_W-1:0] win_len,
  output logic             dout_pos,
  output logic             dout_neg
);

  localparam int PH = 3;

  logic [PH-1:0]   ck;
  logic [2*PH-1:0] s1;
  logic [PH-1:0]   s2p, s2n;
  logic [2*PH-1:0] s3;

  assign ck = {clk_p120, clk_p60, clk_p0};

  // first stage: one flop per sampling edge
  for (genvar i = 0; i < PH; i++) begin : g_ph
    logic qr, qf;
    always_ff @(posedge ck[i] or negedge rst_n)
      if (!rst_n) qr <= 1'b0;
      else        qr <= din;
    always_ff @(negedge ck[i] or negedge rst_n)
      if (!rst_n) qf <= 1'b0;
      else        qf <= din;
    assign s1[i]      = qr;
    assign s1[i + PH] = qf;
  end

  // second stage: early group retimed at 180, late group at 360
  always_ff @(negedge clk_p0 or negedge rst_n)
    if (!rst_n) s2p <= '0;
    else        s2p <= s1[PH-1:0];

  always_ff @(posedge clk_p0 or negedge rst_n)
    if (!rst_n) s2n <= '0;
    else        s2n <= s1[2*PH-1:PH];

  // third stage: all six samples on the 0-degree rising edge
  always_ff @(posedge clk_p0 or negedge rst_n)
    if (!rst_n) s3 <= '0;
    else        s3 <= {s2n, s2p};

  // eye finder
  logic [1:0]       auto_sel;
  logic [2:0]       seen, seen_nx;
  logic [WIN_W-1:0] win_cnt, win_last;
  logic             win_end;

  assign seen_nx  = seen | {s3[5] ^ s3[0],
                            (s3[1] ^ s3[2]) | (s3[4] ^ s3[5]),
                            (s3[0] ^ s3[1]) | (s3[3] ^ s3[4])};
  assign win_last = (win_len == '0) ? '0 : win_len - 1'b1;
  assign win_end  = win_cnt >= win_last;

  always_ff @(posedge clk_p0 or negedge rst_n)
    if (!rst_n) begin
      seen     <= '0;
      win_cnt  <= '0;
      auto_sel <= 2'd1;
    end else if (win_end) begin
      seen    <= '0;
      win_cnt <= '0;
      case (seen_nx)
        3'b001:  auto_sel <= 2'd2;
        3'b010:  auto_sel <= 2'd0;
        3'b100:  auto_sel <= 2'd1;
        default: auto_sel <= auto_sel;
      endcase
    end else begin
      seen    <= seen_nx;
      win_cnt <= win_cnt + 1'b1;
    end

  // select registers and output multiplexers
  logic [1:0] sel_pq, sel_nq;

  always_ff @(posedge clk_p0 or negedge rst_n)
    if (!rst_n) begin
      sel_pq   <= 2'd1;
      dout_pos <= 1'b0;
    end else begin
      sel_pq <= auto_en ? auto_sel : sel_pos;
      if (sel_pq != 2'd3) dout_pos <= s3[sel_pq];
    end

  always_ff @(negedge clk_p0 or negedge rst_n)
    if (!rst_n) begin
      sel_nq   <= 2'd1;
      dout_neg <= 1'b0;
    end else begin
      sel_nq <= auto_en ? auto_sel : sel_neg;
      if (sel_nq != 2'd3) dout_neg <= s3[{1'b0, sel_nq} + 3'd3];
    end

  AST_HOLD_POS: assert property (@(posedge clk_p0) disable iff (!rst_n)
    (sel_pq == 2'd3) |=> $stable(dout_pos)); // R4
  AST_HOLD_NEG: assert property (@(negedge clk_p0) disable iff (!rst_n)
    (sel_nq == 2'd3) |=> $stable(dout_neg)); // R4
  AST_PICK_RANGE: assert property (@(posedge clk_p0) disable iff (!rst_n)
    auto_sel != 2'd3); // R6
  AST_PICK_AT_WIN_END: assert property (@(posedge clk_p0) disable iff (!rst_n)
    !win_end |=> $stable(auto_sel)); // R7
  AST_PICK_AMBIG_KEEP: assert property (@(posedge clk_p0) disable iff (!rst_n)
    (win_end && $countones(seen_nx) != 1) |=> $stable(auto_sel)); // R7

endmodule

// File: tb/ddr_phase_aligner_tb.sv
`timescale 1ps/1ps
module ddr_phase_aligner_tb;

  localparam int HALF = 2000;
  localparam int STEP = 667;
  localparam int HM   = 2047;

  logic clk0 = 0, clk60 = 0, clk120 = 0;
  logic rst_n = 0, din = 0, auto_en = 0;
  logic [1:0] sel_pos = 2'd1, sel_neg = 2'd1;
  logic [7:0] win_len = 8'd8;
  logic dout_pos, dout_neg;

  int checks = 0, errors = 0;
  int pcnt = 0;
  int cur_off = 300;
  logic [15:0] lfsr = 16'hACE1;
  logic hb0 [HM+1];
  logic hb1 [HM+1];
  int   hoff [HM+1];

  ddr_phase_aligner #(.WIN_W(8)) u_dut (
    .clk_p0(clk0), .clk_p60(clk60), .clk_p120(clk120), .rst_n(rst_n),
    .din(din), .sel_pos(sel_pos), .sel_neg(sel_neg), .auto_en(auto_en),
    .win_len(win_len), .dout_pos(dout_pos), .dout_neg(dout_neg));

  initial forever #HALF clk0 = ~clk0;
  initial begin #STEP;     forever #HALF clk60  = ~clk60;  end
  initial begin #(2*STEP-1); forever #HALF clk120 = ~clk120; end

  task automatic next_bit(output logic b);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    b = lfsr[0];
  endtask

  // two bits per period, boundaries at cur_off and cur_off + HALF
  initial begin
    forever begin
      int idx, o;
      logic b0, b1;
      @(posedge clk0);
      idx = pcnt & HM;
      pcnt = pcnt + 1;
      o = cur_off;
      next_bit(b0);
      next_bit(b1);
      hb0[idx] = b0; hb1[idx] = b1; hoff[idx] = o;
      #(o) din = b0;
      #HALF din = b1;
    end
  end

  function automatic logic samp(int m, int x);
    int i = m & HM;
    if (x < hoff[i])             return hb1[(m - 1) & HM];
    else if (x < hoff[i] + HALF) return hb0[i];
    else                         return hb1[i];
  endfunction

  function automatic int off_of(int c);
    return (c == 0) ? 300 : (c == 1) ? 1000 : 1700;
  endfunction

  function automatic int pick_of(int c);
    return (c == 0) ? 2 : (c == 1) ? 0 : 1;
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // {off[1:0], sel_pos, sel_neg, auto, periods[7:0], first_check[7:0]}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 2'd1, 2'd1, 1'b0, 8'd20, 8'd3},
    {2'd0, 2'd2, 2'd2, 1'b0, 8'd20, 8'd3},
    {2'd0, 2'd0, 2'd0, 1'b0, 8'd20, 8'd3},
    {2'd1, 2'd0, 2'd2, 1'b0, 8'd20, 8'd3},
    {2'd1, 2'd2, 2'd1, 1'b0, 8'd20, 8'd3},
    {2'd2, 2'd1, 2'd0, 1'b0, 8'd20, 8'd3},
    {2'd2, 2'd3, 2'd3, 1'b0, 8'd12, 8'd3},
    {2'd2, 2'd0, 2'd1, 1'b0, 8'd20, 8'd3},
    {2'd0, 2'd0, 2'd0, 1'b1, 8'd60, 8'd35},
    {2'd1, 2'd1, 2'd2, 1'b1, 8'd60, 8'd35},
    {2'd2, 2'd3, 2'd3, 1'b1, 8'd60, 8'd35},
    {2'd0, 2'd1, 2'd2, 1'b0, 8'd20, 8'd3}
  };

  logic done = 0;

  initial begin
    #(20000 * 2 * HALF);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev_p, prev_n;
    prev_p = 1; prev_n = 1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk0); #1000;
      check("R1", "reset dout_pos", dout_pos, 1'b0);
      check("R1", "reset dout_neg", dout_neg, 1'b0);
    end
    rst_n = 1;
    repeat (4) @(posedge clk0);

    for (int e = 0; e < NV; e++) begin
      int c, sp, sn, np, c0, k0, ep, en;
      logic au, hp, hn, xp, xn;
      c  = int'(VEC[e][22:21]);
      sp = int'(VEC[e][20:19]);
      sn = int'(VEC[e][18:17]);
      au = VEC[e][16];
      np = int'(VEC[e][15:8]);
      c0 = int'(VEC[e][7:0]);
      @(posedge clk0); #1000;
      k0 = pcnt - 1;
      sel_pos = 2'(sp); sel_neg = 2'(sn); auto_en = au; cur_off = off_of(c);
      hp = samp(k0 - 1, prev_p * STEP);
      hn = samp(k0 - 2, HALF + prev_n * STEP);
      ep = au ? pick_of(c) : sp;
      en = au ? pick_of(c) : sn;
      for (int j = 0; j < np; j++) begin
        int k;
        if (j > 0) begin @(posedge clk0); #1000; end
        k = pcnt - 1;
        if (j >= c0) begin
          if (au) begin
            xp = samp(k - 2, ep * STEP);
            xn = samp(k - 3, HALF + en * STEP);
            check("R6", "auto dout_pos", dout_pos, xp);
            check("R7", "auto dout_neg", dout_neg, xn);
          end else if (sp == 3) begin
            check("R4", "hold dout_pos", dout_pos, hp);
            check("R4", "hold dout_neg", dout_neg, hn);
          end else begin
            xp = samp(k - 2, sp * STEP);
            xn = samp(k - 3, HALF + sn * STEP);
            check((j == c0) ? "R5" : "R2", "dout_pos", dout_pos, xp);
            check((j == c0) ? "R5" : "R3", "dout_neg", dout_neg, xn);
          end
        end
      end
      if (!(sp == 3 && !au)) begin prev_p = ep; prev_n = en; end
    end

    @(posedge clk0); #1000;
    rst_n = 0;
    #10;
    check("R1", "mid-run reset dout_pos", dout_pos, 1'b0);
    check("R1", "mid-run reset dout_neg", dout_neg, 1'b0);
    @(posedge clk0); #1000;
    check("R1", "held reset dout_pos", dout_pos, 1'b0);
    check("R1", "held reset dout_neg", dout_neg, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule